// File: doc/BRIEF.md
# Single-Ended SAR Conversion Controller

This block sequences one successive-approximation converter slice. It runs from the bit-cycling clock. Each conversion frame lasts eight clock cycles. The first cycle of a frame is a settle cycle: the upstream sampler drives the slice input and the comparator stays idle. The other seven cycles each issue one comparator strobe and resolve one bit, most significant bit first.

The switching is single-ended. Only the positive capacitor array is driven. The negative input rests on a dummy array that never switches, so it holds constant while the positive node is stepped toward it by binary weights of 32, 16, 8, 4, 2 and 1 units. Each capacitor has two switch controls. With both controls low the capacitor stays at the mid reference it was sampled on. Raising the "up" control adds its weight to the positive node, and raising the "down" control subtracts it. The first decision needs no switch and the last decision needs no further switch, which is how six capacitors give a 7-bit code. The code is wider than the target resolution so that gain and offset across slices can be trimmed digitally later.

A start strobe realigns the frame to a fresh settle cycle. The 7-bit code appears together with a one-cycle done pulse.

Top module: `sar_se_ctrl`

## Requirements
- R1: While start_i is low, track_o is high for exactly one cycle in every eight consecutive cycles. The seven cycles between two track cycles form one conversion frame.
- R2: cmp_strobe_o is high in each of the seven comparison cycles and low in the settle cycle. track_o is high only in the settle cycle.
- R3: In the settle cycle and in the first comparison cycle, every bit of dac_up_o and dac_dn_o is 0.
- R4: Comparison k (k = 1..6) sets the controls of the capacitor with weight 2^(6-k), which is index 6-k. If comp_i was 1 (positive node above negative node), that capacitor's dac_dn_o bit becomes 1. Otherwise its dac_up_o bit becomes 1. The new setting is visible from the next cycle on, and exactly one capacitor is newly set per comparison. The seventh comparison changes no control.
- R5: code_o bit 6-(k-1) holds the comp_i value sampled in comparison k, so the most significant bit comes first. With an ideal comparator, the code equals the input level in LSB units, from 0 to 127.
- R6: done_o is high for one cycle only, in the settle cycle that follows the seventh comparison. code_o takes its new value in that same cycle and holds it in every other cycle.
- R7: start_i high in any cycle makes the next cycle a settle cycle with all DAC controls cleared. The interrupted frame raises no done_o and leaves code_o unchanged.
- R8: Asserting rst_n low immediately forces track_o high, clears both DAC control words, clears done_o and sets code_o to 0. After release, a frame starts with its settle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-cycling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Frame realign strobe; the next cycle becomes a settle cycle |
| comp_i | input | 1 | Comparator decision, 1 when the positive node is above the negative node |
| dac_up_o | output | 6 | Per-capacitor control that adds the capacitor weight to the positive node |
| dac_dn_o | output | 6 | Per-capacitor control that subtracts the capacitor weight from the positive node |
| track_o | output | 1 | High in the settle cycle |
| cmp_strobe_o | output | 1 | Comparator strobe, high in each comparison cycle |
| code_o | output | 7 | Converted code, most significant bit first |
| done_o | output | 1 | One-cycle pulse when code_o is updated |

## Verification
A behavioural comparator in the bench closes the loop through the two DAC control words. Input levels from random draws check that the binary search lands on the ideal code. The end codes 0 and 127 and the mid-scale pair 63 and 64 force every decision in one direction or flip only the first decision. The alternating patterns 85 and 42 catch weight or bit-order swaps, since those would scramble the result. Frames cut short by start_i or by reset show whether stale decisions leak into the code or raise a done pulse.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  // Width of the phase counter for a frame of nbit comparisons plus one settle cycle.
  function automatic int ph_bits(input int nbit);
    return $clog2(nbit + 1);
  endfunction

  // Number of switched capacitors: the first and last decisions need no switch of their own.
  function automatic int cap_count(input int nbit);
    return nbit - 1;
  endfunction

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq #(
  parameter int NBIT = 7,
  localparam int PH_W = sar_ctrl_pkg::ph_bits(NBIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic [PH_W-1:0] ph_o,
  output logic            track_o,
  output logic            strobe_o,
  output logic            last_o,
  output logic            wrap_o
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NBIT);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  // next state: settle after the last comparison or on a realign strobe
  always_comb begin
    if (wrap_o) ph_d = '0;
    else        ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph_o     = ph_q;
  assign last_o   = (ph_q == LAST_PH);
  assign wrap_o   = last_o | start_i;
  assign track_o  = (ph_q == '0);
  assign strobe_o = ~track_o;

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> track_o); // R1

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_o && !start_i) |=> (ph_q == $past(ph_q) + 1'b1)); // R1

  AST_REALIGN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> track_o); // R7

endmodule

// File: rtl/sar_cap_switch.sv
module sar_cap_switch #(
  parameter int NBIT = 7,
  localparam int PH_W = sar_ctrl_pkg::ph_bits(NBIT),
  localparam int NCAP = sar_ctrl_pkg::cap_count(NBIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_i,
  input  logic            strobe_i,
  input  logic            wrap_i,
  input  logic            comp_i,
  output logic [NCAP-1:0] up_o,
  output logic [NCAP-1:0] dn_o
);

  logic [NCAP-1:0] up_q;
  logic [NCAP-1:0] dn_q;

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    // comparison 1 decides the largest capacitor (index NCAP-1)
    localparam logic [PH_W-1:0] MY_PH = PH_W'(NCAP - j);

    logic set_en;
    logic ld_en;
    logic up_d;
    logic dn_d;

    assign set_en = strobe_i && (ph_i == MY_PH);
    assign ld_en  = wrap_i | set_en;

    always_comb begin
      if (wrap_i) begin
        up_d = 1'b0;
        dn_d = 1'b0;
      end else begin
        up_d = ~comp_i;
        dn_d = comp_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_q[j] <= 1'b0;
        dn_q[j] <= 1'b0;
      end else if (ld_en) begin
        up_q[j] <= up_d;
        dn_q[j] <= dn_d;
      end
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_ONE_CAP_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |-> ($countones(up_q | dn_q) == int'(ph_i) - 1)); // R4

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int NBIT = 7,
  localparam int PH_W = sar_ctrl_pkg::ph_bits(NBIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_i,
  input  logic            strobe_i,
  input  logic            last_i,
  input  logic            start_i,
  input  logic            comp_i,
  output logic [NBIT-1:0] code_o,
  output logic            done_o
);

  logic [NBIT-1:1] dec_q;
  logic [NBIT-1:0] code_q;
  logic [NBIT-1:0] code_d;
  logic            load_en;
  logic            done_q;

  // decision of comparison k lands in bit NBIT-k; bit 0 is taken straight from the last compare
  for (genvar i = 1; i < NBIT; i++) begin : g_dec
    localparam logic [PH_W-1:0] MY_PH = PH_W'(NBIT - i);
    logic cap_en;

    assign cap_en = strobe_i && (ph_i == MY_PH);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dec_q[i] <= 1'b0;
      else if (cap_en) dec_q[i] <= comp_i;
    end
  end

  assign load_en = last_i && !start_i;
  assign code_d  = {dec_q, comp_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (load_en) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= load_en;
  end

  assign code_o = code_q;
  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o)); // R6

endmodule

// File: rtl/sar_se_ctrl.sv
module sar_se_ctrl #(
  parameter int NBIT = 7,
  localparam int PH_W = sar_ctrl_pkg::ph_bits(NBIT),
  localparam int NCAP = sar_ctrl_pkg::cap_count(NBIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            comp_i,
  output logic [NCAP-1:0] dac_up_o,
  output logic [NCAP-1:0] dac_dn_o,
  output logic            track_o,
  output logic            cmp_strobe_o,
  output logic [NBIT-1:0] code_o,
  output logic            done_o
);

  logic [PH_W-1:0] ph;
  logic            strobe;
  logic            last;
  logic            wrap;

  sar_phase_seq #(.NBIT(NBIT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ph_o     (ph),
    .track_o  (track_o),
    .strobe_o (strobe),
    .last_o   (last),
    .wrap_o   (wrap)
  );

  sar_cap_switch #(.NBIT(NBIT)) u_caps (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_i     (ph),
    .strobe_i (strobe),
    .wrap_i   (wrap),
    .comp_i   (comp_i),
    .up_o     (dac_up_o),
    .dn_o     (dac_dn_o)
  );

  sar_code_reg #(.NBIT(NBIT)) u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_i     (ph),
    .strobe_i (strobe),
    .last_i   (last),
    .start_i  (start_i),
    .comp_i   (comp_i),
    .code_o   (code_o),
    .done_o   (done_o)
  );

  assign cmp_strobe_o = strobe;

  AST_SETTLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    track_o |-> (dac_up_o == '0 && dac_dn_o == '0)); // R3

  AST_DONE_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> track_o); // R6

  AST_STROBE_NOT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    track_o |-> !cmp_strobe_o); // R2

endmodule

// File: tb/sar_se_ctrl_bench.sv
`timescale 1ns/1ps
module sar_se_ctrl_bench;

  localparam int NBIT = 7;
  localparam int NCAP = NBIT - 1;

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic            comp_i;
  logic [NCAP-1:0] dac_up_o;
  logic [NCAP-1:0] dac_dn_o;
  logic            track_o;
  logic            cmp_strobe_o;
  logic [NBIT-1:0] code_o;
  logic            done_o;

  int vin2;      // input level in half-LSB units
  int errors;
  int checks;
  int prev_code;
  bit finished;

  sar_se_ctrl u_sar_se_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .comp_i       (comp_i),
    .dac_up_o     (dac_up_o),
    .dac_dn_o     (dac_dn_o),
    .track_o      (track_o),
    .cmp_strobe_o (cmp_strobe_o),
    .code_o       (code_o),
    .done_o       (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural comparator: positive node = input +/- switched weights, negative node at mid-scale
  always_comb begin
    int acc;
    acc = vin2 - 2 * (1 << (NBIT - 1));
    for (int j = 0; j < NCAP; j++) begin
      if (dac_up_o[j]) acc = acc + 2 * (1 << j);
      if (dac_dn_o[j]) acc = acc - 2 * (1 << j);
    end
    comp_i = (acc > 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal_bit(input int code, input int pos);
    return (code >> pos) & 1;
  endfunction

  // Called at a negedge inside a settle cycle; ends at the negedge of the next settle cycle.
  task automatic run_frame(input int code);
    vin2 = 2 * code + 1;
    for (int k = 1; k <= NBIT; k++) begin
      @(negedge clk);
      chk("R2 track low in compare", int'(track_o), 0);
      chk("R2 strobe in compare", int'(cmp_strobe_o), 1);
      chk("R4 caps set so far", $countones({dac_up_o, dac_dn_o}), k - 1);
      if (k == 1) chk("R3 dac clear at first compare", int'({dac_up_o, dac_dn_o}), 0);
      if (k >= 2) begin
        // comparison k-1 decided capacitor index NBIT-k from code bit NBIT+1-k
        chk("R4 down control", int'(dac_dn_o[NBIT-k]), ideal_bit(code, NBIT + 1 - k));
        chk("R4 up control", int'(dac_up_o[NBIT-k]), 1 - ideal_bit(code, NBIT + 1 - k));
      end
      chk("R6 no done mid-frame", int'(done_o), 0);
      chk("R6 code held", int'(code_o), prev_code);
    end
    @(negedge clk);
    chk("R1 settle after eight cycles", int'(track_o), 1);
    chk("R2 no strobe in settle", int'(cmp_strobe_o), 0);
    chk("R3 dac clear in settle", int'({dac_up_o, dac_dn_o}), 0);
    chk("R6 done pulse", int'(done_o), 1);
    chk("R5 code", int'(code_o), code);
    prev_code = code;
  endtask

  initial begin
    errors    = 0;
    checks    = 0;
    finished  = 1'b0;
    prev_code = 0;
    vin2      = 1;
    start_i   = 1'b0;
    rst_n     = 1'b0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 track in reset", int'(track_o), 1);
    chk("R8 dac in reset", int'({dac_up_o, dac_dn_o}), 0);
    chk("R8 done in reset", int'(done_o), 0);
    chk("R8 code in reset", int'(code_o), 0);
    rst_n = 1'b1;

    // directed corners
    run_frame(0);
    run_frame(127);
    run_frame(63);
    run_frame(64);
    run_frame(1);
    run_frame(126);
    run_frame(85);
    run_frame(42);

    // R1 done stays single across back-to-back frames
    @(negedge clk);
    chk("R6 done one cycle", int'(done_o), 0);
    chk("R1 compare follows settle", int'(track_o), 0);
    // finish this frame with any input, then resume in settle
    repeat (NBIT - 1) @(negedge clk);
    @(negedge clk);
    prev_code = int'(code_o);

    // R7 realign in mid-frame
    run_frame(100);
    vin2 = 2 * 17 + 1;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 settle after start", int'(track_o), 1);
    chk("R7 dac cleared after start", int'({dac_up_o, dac_dn_o}), 0);
    chk("R7 no done for aborted frame", int'(done_o), 0);
    chk("R7 code unchanged", int'(code_o), 100);
    run_frame(17);

    // R7 start during last compare suppresses done
    vin2 = 2 * 90 + 1;
    repeat (NBIT) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 start on last compare, no done", int'(done_o), 0);
    chk("R7 code kept", int'(code_o), 17);
    run_frame(90);

    // R8 asynchronous reset in mid-frame
    vin2 = 2 * 50 + 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 track forced", int'(track_o), 1);
    chk("R8 dac cleared", int'({dac_up_o, dac_dn_o}), 0);
    chk("R8 code cleared", int'(code_o), 0);
    chk("R8 done cleared", int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_code = 0;
    run_frame(50);

    // R5 random sweep
    for (int i = 0; i < 200; i++) begin
      run_frame(int'($urandom % 128));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule